// File: doc/BRIEF.md
# Synchronous Slave Serial Transmitter

This block sends 8- or 9-bit words on a serial data line, one bit per edge of a clock supplied by an external master. No clock is generated here: the external clock pin is brought into the system clock domain through a two-flop synchronizer. An edge detector then turns it into a single-cycle strobe that advances the shift logic.

Software writes a byte to a holding register through a simple write strobe. In 9-bit mode, the top bit comes from a separate one-bit register that must be written earlier. Words move from the holding register into a shift register. With the two registers, one word can wait while another is shifting out. Status outputs report whether the holding register can take a word and whether the shifter is idle. An interrupt request is raised when the holding register is free and interrupts are enabled.

Top module: `sst_tx`

## Requirements
- R1: Transmission is active only when `sync_mode_i`=1, `clk_master_i`=0, `rx_single_i`=0, `rx_cont_i`=0, `port_en_i`=1 and `tx_en_i`=1. In any other setting, `sdo_oe_o` is 0 and data writes are ignored (`shreg_empty_o` stays 1, `buf_empty_o` stays 1).
- R2: When the active condition drops, the shifter and the holding register are cleared on the next clock, and both `buf_empty_o` and `shreg_empty_o` read 1.
- R3: A data write while the shifter is idle loads the word straight into the shifter. On the next cycle, `shreg_empty_o`=0, `buf_empty_o` stays 1 and `sdo_o` shows bit 0.
- R4: A data write while a word is shifting is held in the holding register, and `buf_empty_o` reads 0 on the next cycle.
- R5: When the current word finishes and the holding register is full, the held word moves into the shifter on the same drive edge. `buf_empty_o` then returns to 1 and the next word continues with no idle bit.
- R6: Bits leave least significant first. With `len9_i`=0 a word is 8 bits long. With `len9_i`=1 it is 9 bits, and bit 8 is the value of the ninth-bit register, written by `wr_bit9_en_i`, as it stood before the data write.
- R7: A drive edge is a falling edge of `sck_i` when `clk_pol_i`=0 and a rising edge when `clk_pol_i`=1. `sdo_o` changes only on a drive edge or a load. The word ends on the drive edge that follows its last bit.
- R8: `shreg_empty_o` is 1 whenever no word is loaded or shifting. While active and idle, `sdo_o` is 1.
- R9: `irq_o` is 1 exactly when `buf_empty_o`=1 and `irq_en_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the external master |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the data line |
| wr_data_i | input | 8 | Byte to transmit |
| wr_data_en_i | input | 1 | Write strobe for the data byte |
| wr_bit9_i | input | 1 | Ninth-bit value |
| wr_bit9_en_i | input | 1 | Write strobe for the ninth-bit register |
| sync_mode_i | input | 1 | Synchronous mode select |
| clk_master_i | input | 1 | Clock-source select; 1 means master |
| rx_single_i | input | 1 | Single-receive enable |
| rx_cont_i | input | 1 | Continuous-receive enable |
| port_en_i | input | 1 | Serial port enable |
| tx_en_i | input | 1 | Transmit enable |
| len9_i | input | 1 | 9-bit word select |
| clk_pol_i | input | 1 | Drive-edge select |
| irq_en_i | input | 1 | Transmit interrupt enable |
| buf_empty_o | output | 1 | Holding register free |
| shreg_empty_o | output | 1 | Shifter idle |
| irq_o | output | 1 | Transmit interrupt request |

## Verification
The properties assume that the external master holds each level of `sck_i` for longer than the synchronizer latency of three system clocks. They also assume that polarity and word length change only while transmission is inactive, so a mode change cannot create a drive edge by itself. The bench holds each clock phase for six system clocks. It changes `clk_pol_i` and the idle level of `sck_i` only while `tx_en_i` is low, and it samples `sdo_o` at the end of each phase, just before it makes the next drive edge.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int DATA_W = 8;
  localparam int WORD_W = DATA_W + 1;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  typedef struct packed {
    logic              ext;
    logic [DATA_W-1:0] data;
  } word_t;
endpackage

// File: rtl/sst_sck_sync.sv
module sst_sck_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic pol_i,
  output logic drv_edge_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q[0] <= 1'b0;
    else         q[0] <= sck_i;
  end

  for (genvar g = 1; g <= LAST; g++) begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[g] <= 1'b0;
      else         q[g] <= q[g-1];
    end
  end

  logic cur, prev;
  assign cur  = q[LAST-1];
  assign prev = q[LAST];

  // pol 1: rising edge drives, pol 0: falling edge drives
  assign drv_edge_o = pol_i ? (cur & ~prev) : (~cur & prev);
endmodule

// File: rtl/sst_hold.sv
module sst_hold
  import sst_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  cap_i,
  input  logic  take_i,
  input  word_t word_i,
  output word_t word_o,
  output logic  full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      word_o <= '0;
    end else if (clr_i) begin
      full_o <= 1'b0;
      word_o <= '0;
    end else if (cap_i) begin
      full_o <= 1'b1;
      word_o <= word_i;
    end else if (take_i) begin
      full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
  import sst_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  load_i,
  input  word_t word_i,
  input  logic  len9_i,
  input  logic  adv_i,
  output logic  bit_o,
  output logic  busy_o,
  output logic  done_o
);
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  last_q;
  logic              at_last;

  assign at_last = (cnt_q == last_q);
  assign done_o  = adv_i & busy_o & at_last;
  assign bit_o   = sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      last_q <= '0;
      busy_o <= 1'b0;
    end else if (clr_i) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
    end else if (load_i) begin
      sh_q   <= word_i;
      cnt_q  <= '0;
      last_q <= len9_i ? CNT_W'(WORD_W - 1) : CNT_W'(DATA_W - 1);
      busy_o <= 1'b1;
    end else if (adv_i && busy_o) begin
      if (at_last) begin
        busy_o <= 1'b0;
      end else begin
        sh_q  <= {1'b0, sh_q[WORD_W-1:1]};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sst_tx.sv
module sst_tx
  import sst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_data_en_i,
  input  logic              wr_bit9_i,
  input  logic              wr_bit9_en_i,
  input  logic              sync_mode_i,
  input  logic              clk_master_i,
  input  logic              rx_single_i,
  input  logic              rx_cont_i,
  input  logic              port_en_i,
  input  logic              tx_en_i,
  input  logic              len9_i,
  input  logic              clk_pol_i,
  input  logic              irq_en_i,
  output logic              buf_empty_o,
  output logic              shreg_empty_o,
  output logic              irq_o
);
  logic  gate_ok, drv_edge, sh_busy, sh_done, sh_bit, sh_load;
  logic  hold_full, hold_cap, load_hold, load_wr, bit9_q;
  word_t hold_word, wr_word, sh_word;

  assign gate_ok = sync_mode_i & ~clk_master_i & ~rx_single_i & ~rx_cont_i
                 & port_en_i & tx_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           bit9_q <= 1'b0;
    else if (wr_bit9_en_i) bit9_q <= wr_bit9_i;
  end

  assign wr_word = '{ext: bit9_q, data: wr_data_i};

  sst_sck_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_i      (sck_i),
    .pol_i      (clk_pol_i),
    .drv_edge_o (drv_edge)
  );

  // held word wins at handoff; a fresh write goes straight in only if the shifter frees up
  assign load_hold = gate_ok & sh_done & hold_full;
  assign load_wr   = gate_ok & wr_data_en_i & (~sh_busy | (sh_done & ~hold_full));
  assign hold_cap  = gate_ok & wr_data_en_i & ~load_wr;
  assign sh_load   = load_hold | load_wr;
  assign sh_word   = load_hold ? hold_word : wr_word;

  sst_hold u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~gate_ok),
    .cap_i  (hold_cap),
    .take_i (load_hold),
    .word_i (wr_word),
    .word_o (hold_word),
    .full_o (hold_full)
  );

  sst_shifter u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~gate_ok),
    .load_i (sh_load),
    .word_i (sh_word),
    .len9_i (len9_i),
    .adv_i  (drv_edge),
    .bit_o  (sh_bit),
    .busy_o (sh_busy),
    .done_o (sh_done)
  );

  assign sdo_oe_o      = gate_ok;
  assign sdo_o         = sh_busy ? sh_bit : 1'b1;
  assign buf_empty_o   = ~hold_full;
  assign shreg_empty_o = ~sh_busy;
  assign irq_o         = buf_empty_o & irq_en_i;
endmodule

// File: rtl/sst_tx_chk.sv
module sst_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sdo_o,
  input logic sdo_oe_o,
  input logic wr_data_en_i,
  input logic rx_single_i,
  input logic rx_cont_i,
  input logic port_en_i,
  input logic tx_en_i,
  input logic irq_en_i,
  input logic buf_empty_o,
  input logic shreg_empty_o,
  input logic irq_o,
  input logic drv_edge
);
  p_rx_no_drive_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_single_i || rx_cont_i) |-> !sdo_oe_o);

  p_off_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!port_en_i || !tx_en_i) |=> (buf_empty_o && shreg_empty_o));

  p_idle_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o && wr_data_en_i && shreg_empty_o) |=> (!shreg_empty_o && buf_empty_o));

  p_hold_needs_shift_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !buf_empty_o |-> !shreg_empty_o);

  p_line_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shreg_empty_o && $past(!shreg_empty_o) && !$past(drv_edge) && $past(sdo_oe_o))
      |-> $stable(sdo_o));

  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en_i && buf_empty_o));
endmodule

bind sst_tx sst_tx_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sdo_o         (sdo_o),
  .sdo_oe_o      (sdo_oe_o),
  .wr_data_en_i  (wr_data_en_i),
  .rx_single_i   (rx_single_i),
  .rx_cont_i     (rx_cont_i),
  .port_en_i     (port_en_i),
  .tx_en_i       (tx_en_i),
  .irq_en_i      (irq_en_i),
  .buf_empty_o   (buf_empty_o),
  .shreg_empty_o (shreg_empty_o),
  .irq_o         (irq_o),
  .drv_edge      (drv_edge)
);

// File: tb/sst_tx_test.sv
module sst_tx_test;
  localparam int H = 6;
  localparam int NV = 6;
  // {len9, pol, bit9, data}
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 8'hA5},
    {1'b0, 1'b1, 1'b0, 8'h3C},
    {1'b1, 1'b0, 1'b1, 8'h00},
    {1'b1, 1'b1, 1'b0, 8'hFF},
    {1'b1, 1'b0, 1'b0, 8'h81},
    {1'b0, 1'b1, 1'b1, 8'h5A}
  };

  logic clk = 1'b0, rst_ni = 1'b0, sck = 1'b1;
  logic sdo_o, sdo_oe_o, buf_empty_o, shreg_empty_o, irq_o;
  logic [7:0] wr_data = '0;
  logic wr_data_en = 0, wr_bit9 = 0, wr_bit9_en = 0;
  logic sync_mode = 0, clk_master = 0, rx_single = 0, rx_cont = 0;
  logic port_en = 0, tx_en = 0, len9 = 0, clk_pol = 0, irq_en = 0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sst_tx uut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .wr_data_i(wr_data), .wr_data_en_i(wr_data_en), .wr_bit9_i(wr_bit9),
    .wr_bit9_en_i(wr_bit9_en), .sync_mode_i(sync_mode), .clk_master_i(clk_master),
    .rx_single_i(rx_single), .rx_cont_i(rx_cont), .port_en_i(port_en),
    .tx_en_i(tx_en), .len9_i(len9), .clk_pol_i(clk_pol), .irq_en_i(irq_en),
    .buf_empty_o(buf_empty_o), .shreg_empty_o(shreg_empty_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] d);
    wr_data = d; wr_data_en = 1'b1;
    @(negedge clk);
    wr_data_en = 1'b0;
  endtask

  task automatic wr_b9(input logic b);
    wr_bit9 = b; wr_bit9_en = 1'b1;
    @(negedge clk);
    wr_bit9_en = 1'b0;
  endtask

  // acts as master: sample, drive edge, return edge
  task automatic clock_word(input int n, output logic [8:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      got[i] = sdo_o;
      sck = ~sck;
      repeat (H) @(negedge clk);
      sck = ~sck;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic setup(input logic pol, input logic l9);
    tx_en = 1'b0;
    @(negedge clk);
    clk_pol = pol; len9 = l9; sck = ~pol;
    repeat (4) @(negedge clk);
    tx_en = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [8:0] got;
    repeat (3) @(negedge clk);
    // reset state
    chk("R8 reset shreg_empty", shreg_empty_o, 1);
    chk("R2 reset buf_empty", buf_empty_o, 1);
    chk("R1 reset oe", sdo_oe_o, 0);
    chk("R9 reset irq", irq_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    sync_mode = 1; port_en = 1;

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [8:0] exp9;
      int n;
      setup(VEC[v][9], VEC[v][10]);
      chk("R8 idle sdo", sdo_o, 1);
      wr_b9(VEC[v][8]);
      wr_byte(VEC[v][7:0]);
      chk("R3 loaded shreg_empty", shreg_empty_o, 0);
      chk("R3 buf_empty after idle write", buf_empty_o, 1);
      n = VEC[v][10] ? 9 : 8;
      exp9 = VEC[v][10] ? {VEC[v][8], VEC[v][7:0]} : {1'b0, VEC[v][7:0]};
      clock_word(n, got);
      chk("R6 R7 word bits", got, exp9);
      chk("R8 empty after word", shreg_empty_o, 1);
      chk("R8 sdo idle after word", sdo_o, 1);
    end

    // double buffering and interrupt
    setup(1'b0, 1'b0);
    irq_en = 1;
    @(negedge clk);
    chk("R9 irq with empty buffer", irq_o, 1);
    wr_byte(8'hC3);
    wr_byte(8'h96);
    chk("R4 buf_empty held", buf_empty_o, 0);
    chk("R9 irq low while held", irq_o, 0);
    clock_word(8, got);
    chk("R6 first word", got, 9'h0C3);
    chk("R5 buf_empty after handoff", buf_empty_o, 1);
    chk("R5 shifter still busy", shreg_empty_o, 0);
    chk("R9 irq after handoff", irq_o, 1);
    clock_word(8, got);
    chk("R5 second word", got, 9'h096);
    chk("R8 empty after both", shreg_empty_o, 1);
    irq_en = 0;
    @(negedge clk);
    chk("R9 irq masked", irq_o, 0);

    // disable mid word
    wr_byte(8'h55);
    wr_byte(8'hAA);
    clock_word(3, got);
    chk("R4 held before disable", buf_empty_o, 0);
    tx_en = 0;
    repeat (2) @(negedge clk);
    chk("R2 buf_empty after disable", buf_empty_o, 1);
    chk("R2 shreg_empty after disable", shreg_empty_o, 1);
    chk("R1 oe off", sdo_oe_o, 0);
    setup(1'b0, 1'b0);
    chk("R2 idle after re-enable", shreg_empty_o, 1);
    chk("R2 sdo idle after re-enable", sdo_o, 1);

    // receive mode and master mode block transmit
    rx_cont = 1;
    @(negedge clk);
    chk("R1 oe off in receive", sdo_oe_o, 0);
    wr_byte(8'h12);
    @(negedge clk);
    chk("R1 write ignored in receive", shreg_empty_o, 1);
    rx_cont = 0; clk_master = 1;
    @(negedge clk);
    wr_byte(8'h34);
    @(negedge clk);
    chk("R1 write ignored as master", shreg_empty_o, 1);
    chk("R1 oe off as master", sdo_oe_o, 0);
    clk_master = 0;
    @(negedge clk);
    chk("R1 oe back on", sdo_oe_o, 1);
    chk("R1 nothing queued", shreg_empty_o, 1);
    wr_byte(8'h0F);
    clock_word(8, got);
    chk("R6 word after mode restore", got, 9'h00F);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule